// File: doc/BRIEF.md
# Drift-Prone Level Population Pre-Screen

This block sits in the read path of a memory line built from 256 two-bit cells. It gives a cheap first look at whether the line needs a full error-correcting decode. The line is divided into eight fields of 32 cells. Some cell levels are susceptible to resistance drift. For each field, the block counts how many cells hold one of those levels.

When the line is written, including the rewrite that follows a scrub, the block stores the eight counts as check metadata. On each periodic check-read, it recounts the levels in the data just read and compares the result with the stored values field by field. If any field's count has moved, a decode request is raised so the full decoder runs. If no count moved, the line skips the decoder. An eight-bit vector reports which fields disagreed.

Top module: `drift_count_checker`

## Requirements
- R1: After reset, `res_valid`, `mismatch` and `decode_req` are 0 and every stored field count is zero. A check of an all-`00` line before any write therefore reports no mismatch.
- R2: Cell i occupies line bits [2i+1:2i] and belongs to field i/32. A cell is drift-prone when bit v of the parameter `PRONE_MASK` is set, where v is the cell value. The default mask 4'b0110 marks values 01 and 10 only.
- R3: On a clock edge with `wr_valid` high, the stored counts take the per-field counts of `wr_data`. A scrub rewrite is such a write and refreshes the metadata.
- R4: A check presented on a clock edge with `chk_valid` high yields `res_valid` high for exactly the following cycle. With no check, `res_valid` is low.
- R5: In a check result, `mismatch[f]` is 1 exactly when field f's count of `chk_data` differs from its stored count.
- R6: In a check result, `decode_req` is 1 exactly when any `mismatch` bit is 1. A value of 0 means the decoder is bypassed.
- R7: When a write and a check share a clock edge, the check is compared against the counts stored before that write. Later checks see the new counts.
- R8: Only the number of prone cells per field matters. Data that moves cells within a field while keeping its prone count produces no mismatch.
- R9: A field with all 32 cells prone is counted as 32 without wrap. It differs from a field with zero prone cells and matches another field with 32 prone cells.
- R10: While `res_valid` is low, `mismatch` and `decode_req` are 0. A check with `wr_valid` low leaves the stored counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Line write or scrub rewrite this cycle |
| wr_data | input | 512 | Data being written to the line |
| chk_valid | input | 1 | Periodic check-read data present this cycle |
| chk_data | input | 512 | Data read back for the check |
| res_valid | output | 1 | Check result valid |
| mismatch | output | 8 | Per-field count-change flags |
| decode_req | output | 1 | Request for the full decoder |

## Verification
The two functions that can fall in the same cycle are metadata capture from a write and comparison for a check-read. The bench provokes this by raising `wr_valid` and `chk_valid` on the same edge with different lines. It judges the result against the counts held before that edge. It then runs a lone check of the read line, which must now be judged against the newly written counts. A wrong ordering in either direction shows up as a mismatch vector that disagrees with the bench's own per-field tally.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DEF_CELLS     = 256;
  localparam int DEF_CELL_BITS = 2;
  localparam int DEF_FIELDS    = 8;
  localparam logic [3:0] DEF_PRONE_MASK = 4'b0110;

  // a cell is drift-prone when the mask bit selected by its value is set
  function automatic logic cell_is_prone(input logic [1:0] v, input logic [3:0] mask);
    return mask[v];
  endfunction
endpackage

// File: rtl/dcc_pop_bank.sv
module dcc_pop_bank
  import dcc_pkg::*;
#(
  parameter int CELLS = DEF_CELLS,
  parameter int FIELDS = DEF_FIELDS,
  parameter logic [3:0] PRONE_MASK = DEF_PRONE_MASK,
  localparam int CPF = CELLS / FIELDS,
  localparam int CNT_W = $clog2(CPF + 1),
  localparam int LINE_W = CELLS * 2
) (
  input  logic [LINE_W-1:0]            line,
  output logic [FIELDS-1:0][CNT_W-1:0] counts
);
  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    logic [CPF*2-1:0] fbits;
    assign fbits = line[f*CPF*2 +: CPF*2];
    always_comb begin
      counts[f] = '0;
      for (int c = 0; c < CPF; c++) begin
        if (cell_is_prone(fbits[c*2 +: 2], PRONE_MASK))
          counts[f] = counts[f] + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dcc_meta_store.sv
module dcc_meta_store #(
  parameter int FIELDS = 8,
  parameter int CPF = 32,
  localparam int CNT_W = $clog2(CPF + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [FIELDS-1:0][CNT_W-1:0] new_counts,
  output logic [FIELDS-1:0][CNT_W-1:0] stored
);
  always_ff @(posedge clk) begin
    if (!rst_n)        stored <= '0;
    else if (wr_valid) stored <= new_counts;
  end

  // R10: metadata only moves on a write
  p_meta_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(stored));
  // R3: a write lands in the store on the next cycle
  p_meta_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> stored == $past(new_counts));
  // R9: no stored count exceeds the field size
  for (genvar f = 0; f < FIELDS; f++) begin : g_rng
    p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stored[f] <= CNT_W'(CPF));
  end
endmodule

// File: rtl/dcc_compare.sv
module dcc_compare #(
  parameter int FIELDS = 8,
  parameter int CPF = 32,
  localparam int CNT_W = $clog2(CPF + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         chk_valid,
  input  logic [FIELDS-1:0][CNT_W-1:0] live,
  input  logic [FIELDS-1:0][CNT_W-1:0] stored,
  output logic                         res_valid,
  output logic [FIELDS-1:0]            mismatch,
  output logic                         decode_req
);
  logic [FIELDS-1:0] diff;
  for (genvar f = 0; f < FIELDS; f++) begin : g_cmp
    assign diff[f] = live[f] != stored[f];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      mismatch   <= '0;
      decode_req <= 1'b0;
    end else begin
      res_valid  <= chk_valid;
      mismatch   <= chk_valid ? diff : '0;
      decode_req <= chk_valid & (|diff);
    end
  end

  // R4: one result per check, one cycle later
  p_res_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);
  p_res_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);
  // R6: request agrees with the flag vector
  p_req_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
    decode_req == (mismatch != '0));
  // R10: flags are silent outside a result
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (mismatch == '0));
endmodule

// File: rtl/drift_count_checker.sv
module drift_count_checker
  import dcc_pkg::*;
#(
  parameter int CELLS = DEF_CELLS,
  parameter int FIELDS = DEF_FIELDS,
  parameter logic [3:0] PRONE_MASK = DEF_PRONE_MASK,
  localparam int CPF = CELLS / FIELDS,
  localparam int CNT_W = $clog2(CPF + 1),
  localparam int LINE_W = CELLS * 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              chk_valid,
  input  logic [LINE_W-1:0] chk_data,
  output logic              res_valid,
  output logic [FIELDS-1:0] mismatch,
  output logic              decode_req
);
  logic [FIELDS-1:0][CNT_W-1:0] wr_counts;
  logic [FIELDS-1:0][CNT_W-1:0] rd_counts;
  logic [FIELDS-1:0][CNT_W-1:0] meta_q;

  dcc_pop_bank #(.CELLS(CELLS), .FIELDS(FIELDS), .PRONE_MASK(PRONE_MASK))
    u_wr_pop (.line(wr_data), .counts(wr_counts));

  dcc_pop_bank #(.CELLS(CELLS), .FIELDS(FIELDS), .PRONE_MASK(PRONE_MASK))
    u_rd_pop (.line(chk_data), .counts(rd_counts));

  dcc_meta_store #(.FIELDS(FIELDS), .CPF(CPF)) u_meta (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .new_counts(wr_counts), .stored(meta_q));

  dcc_compare #(.FIELDS(FIELDS), .CPF(CPF)) u_cmp (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
    .live(rd_counts), .stored(meta_q),
    .res_valid(res_valid), .mismatch(mismatch), .decode_req(decode_req));

  // R7: a result from a shared-edge write/check uses the pre-write metadata
  p_collide_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && chk_valid) |=> mismatch == $past(u_cmp.diff));
endmodule

// File: tb/sim_drift_count_checker.sv
`timescale 1ns/1ps
module sim_drift_count_checker;
  localparam int LW = 512;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, chk_valid = 1'b0;
  logic [LW-1:0] wr_data = '0, chk_data = '0;
  logic res_valid, decode_req;
  logic [7:0] mismatch;
  int vectors = 0, fails = 0;
  int ref_meta [8];

  always #2.5 clk = ~clk;

  drift_count_checker u0 (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .chk_valid(chk_valid), .chk_data(chk_data), .res_valid(res_valid),
    .mismatch(mismatch), .decode_req(decode_req));

  // bench tally: value 01 or 10 means the two bits differ
  function automatic int tally(input logic [LW-1:0] d, input int f);
    int n = 0;
    for (int i = f*32; i < f*32 + 32; i++) if (d[2*i] ^ d[2*i+1]) n++;
    return n;
  endfunction

  function automatic logic [7:0] expect_vec(input logic [LW-1:0] d);
    logic [7:0] v;
    for (int f = 0; f < 8; f++) v[f] = (tally(d, f) != ref_meta[f]);
    return v;
  endfunction

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] l;
    for (int w = 0; w < LW/32; w++) l[w*32 +: 32] = $urandom;
    return l;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic learn(input logic [LW-1:0] d);
    for (int f = 0; f < 8; f++) ref_meta[f] = tally(d, f);
  endtask

  // one cycle with optional write and check; samples the result at the next negedge
  task automatic step(input logic w, input logic [LW-1:0] wd, input logic c,
                      input logic [LW-1:0] cd, input string req);
    logic [7:0] ev;
    @(negedge clk);
    wr_valid = w; wr_data = wd; chk_valid = c; chk_data = cd;
    ev = c ? expect_vec(cd) : 8'h00;
    @(negedge clk);
    wr_valid = 1'b0; chk_valid = 1'b0;
    if (w) learn(wd);
    check({req, " res_valid"}, 32'(res_valid), 32'(c));
    check({req, " mismatch"}, 32'(mismatch), 32'(ev));
    check({req, " decode_req"}, 32'(decode_req), 32'(ev != 0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 res_valid", 32'(res_valid), 0);
    check("R1 mismatch", 32'(mismatch), 0);
    check("R1 decode_req", 32'(decode_req), 0);
    step(0, '0, 1, '0, "R1 zero line vs reset meta");
    step(0, '0, 0, '0, "R10 idle");
  endtask

  task automatic t_write_match();
    logic [LW-1:0] l;
    for (int k = 0; k < 4; k++) begin
      l = rand_line();
      step(1, l, 0, '0, "R3 write");
      step(0, '0, 1, l, "R5 same data");
      step(0, '0, 1, rand_line(), "R5 random read");
    end
  endtask

  task automatic t_mask_levels();
    logic [LW-1:0] l;
    step(1, '0, 0, '0, "R3 zero write");
    l = '0; l[2*40 +: 2] = 2'b11;
    step(0, '0, 1, l, "R2 level 11 not prone");
    l = '0; l[2*40 +: 2] = 2'b01;
    step(0, '0, 1, l, "R2 level 01 prone");
    l = '0; l[2*200 +: 2] = 2'b10;
    step(0, '0, 1, l, "R2 level 10 prone");
  endtask

  task automatic t_single_field();
    logic [LW-1:0] l, m;
    l = rand_line();
    step(1, l, 0, '0, "R3 write");
    m = l;
    m[2*100 +: 2] = (m[200] ^ m[201]) ? 2'b00 : 2'b01;
    step(0, '0, 1, m, "R5 field 3 changed");
  endtask

  task automatic t_same_count();
    logic [LW-1:0] l, m;
    l = rand_line();
    step(1, l, 0, '0, "R3 write");
    for (int f = 0; f < 8; f++)
      m[f*64 +: 64] = {l[f*64 +: 2], l[f*64+2 +: 62]};
    step(0, '0, 1, m, "R8 cells rotated in field");
  endtask

  task automatic t_full_field();
    logic [LW-1:0] l;
    step(1, '0, 0, '0, "R3 zero write");
    l = '0; l[5*64 +: 64] = {32{2'b01}};
    step(0, '0, 1, l, "R9 32 vs 0");
    step(1, l, 0, '0, "R3 full write");
    l[5*64 +: 64] = {32{2'b10}};
    step(0, '0, 1, l, "R9 32 vs 32");
    l[5*64 +: 64] = {32{2'b11}};
    step(0, '0, 1, l, "R9 0 vs 32");
  endtask

  task automatic t_collide();
    logic [LW-1:0] a, b;
    a = rand_line(); b = rand_line();
    step(1, a, 0, '0, "R3 write");
    a = rand_line();
    step(1, a, 1, b, "R7 shared edge");
    step(0, '0, 1, b, "R7 after shared edge");
    step(0, '0, 1, a, "R7 new meta");
  endtask

  task automatic t_scrub();
    logic [LW-1:0] l, d;
    l = rand_line();
    step(1, l, 0, '0, "R3 write");
    d = l; d[2*10 +: 2] = (d[20] ^ d[21]) ? 2'b11 : 2'b10;
    step(0, '0, 1, d, "R5 drifted");
    step(0, '0, 1, d, "R10 check leaves meta");
    step(1, d, 0, '0, "R3 scrub rewrite");
    step(0, '0, 1, d, "R3 refreshed meta");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int f = 0; f < 8; f++) ref_meta[f] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_write_match();
    t_mask_levels();
    t_single_field();
    t_same_count();
    t_full_field();
    t_collide();
    t_scrub();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule